// File: doc/BRIEF.md
# I2C Host Address-Phase Sequencer

This block is the address stage of a single-master I2C host. Software writes an 8-bit target address. The block then decides what to do from its own record of the bus. That record can be unknown, idle, owned by this host, or busy with another master's traffic. From idle it generates a START, shifts the address out MSB first and samples the acknowledge. Once this is done it parks with SCL pulled low so that a later stage can continue. If it already owns the bus it generates a repeated START instead. When the previous address carried the read direction, it first clocks out the configured acknowledge bit.

The lines are open-drain: an output high means the block pulls that line low. The bus record follows START and STOP conditions seen on the synchronized line inputs. It also follows the host's own actions and a software force-idle strobe. Bit timing comes from a programmable divider. Each SCL low or high half lasts `clk_div_i + 1` clock cycles, and `clk_div_i` must be at least 3.

Top module: `i2c_addr_host`

## Requirements
- R1: The address register is 8 bits, resets to 0, and `addr_o` always shows the value of the last accepted write. Observing it has no effect on the lines.
- R2: Bit 0 of the address is the direction: 0 write, 1 read. A repeated start that follows a read address (acked or not) is preceded by one acknowledge clock pulse. One that follows a write address is not.
- R3: A write while the bus state is unknown (encoding 0) sets `bus_err_o` and `host_flag_o` and causes no line activity.
- R4: A write while the bus state is busy (encoding 3) is held pending with the lines released. It is issued as soon as a STOP returns the state to idle.
- R5: A write while idle (encoding 1) gives a START and then the 8 address bits, MSB first. On ACK, SCL is held low, `clk_hold_o` and `host_flag_o` are set, and the state becomes owner (encoding 2).
- R6: A write while owner gives a repeated START. After a read, the pre-pulse carries `ack_bit_i` as sampled at the write: 0 pulls SDA low, 1 leaves it released.
- R7: In the owner state a write is accepted only while `host_flag_o` is set. Otherwise it changes nothing, including `addr_o`.
- R8: Every accepted write clears `bus_err_o`, `arb_lost_o`, `host_flag_o` and `rx_nack_o`.
- R9: Each SCL half-period lasts `clk_div_i+1` cycles. A fresh transfer takes 19 halves up to `host_flag_o`; a repeated start takes 21, or 23 with the pre-pulse. The host never releases SDA while SCL is high.
- R10: On NACK, `host_flag_o` and `rx_nack_o` are set and SCL is held low.
- R11: If SDA reads low while the host leaves it released during an address bit, `arb_lost_o` and `host_flag_o` are set, both lines are released, and the state becomes busy.
- R12: After reset the state is unknown. `force_idle_i` makes it idle and releases SCL. A STOP makes it idle. A START seen while the host is not the owner makes it busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | 8 | Address write data, bit 0 = direction |
| force_idle_i | input | 1 | Software strobe forcing the bus state to idle |
| ack_bit_i | input | 1 | Acknowledge bit sent before a repeated start after a read |
| clk_div_i | input | 8 | SCL half-period minus one, in clock cycles |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| addr_o | output | 8 | Address register readback |
| bus_state_o | output | 2 | 0 unknown, 1 idle, 2 owner, 3 busy |
| host_flag_o | output | 1 | Host-on-bus interrupt flag |
| bus_err_o | output | 1 | Bus error status |
| arb_lost_o | output | 1 | Arbitration lost status |
| rx_nack_o | output | 1 | Address was not acknowledged |
| clk_hold_o | output | 1 | SCL is being held low after the address phase |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The assertions check every cycle that a write in the unknown state raises the error flags, that an accepted write clears the arbitration flag, and that a rejected owner-state write leaves the register untouched. They also check that a set clock-hold always comes with SCL pulled low, that arbitration loss frees the lines and marks the bus busy, and that SDA holds still during an SCL high half. Only the bench scenarios can show the byte as a target sees it and the exact phase counts. The same holds for the presence and value of the acknowledge pre-pulse, the hand-off of a pending write at a STOP, and the bus-state changes driven by external START and STOP.

// File: rtl/i2c_ah_pkg.sv
package i2c_ah_pkg;
  typedef enum logic [1:0] {
    BS_UNKNOWN = 2'd0,
    BS_IDLE    = 2'd1,
    BS_OWNER   = 2'd2,
    BS_BUSY    = 2'd3
  } bus_state_e;

  typedef enum logic [3:0] {
    E_IDLE, E_START, E_BIT_LO, E_BIT_HI, E_ACK_LO, E_ACK_HI,
    E_HOLD, E_PRE_LO, E_PRE_HI, E_RS_LO, E_RS_HI
  } eng_st_e;
endpackage

// File: rtl/i2c_ah_tick.sv
module i2c_ah_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_ah_mon.sv
module i2c_ah_mon #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s;

  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin scl_ff[0] <= 1'b1; sda_ff[0] <= 1'b1; end
        else         begin scl_ff[0] <= scl_i; sda_ff[0] <= sda_i; end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin scl_ff[g] <= 1'b1; sda_ff[g] <= 1'b1; end
        else         begin scl_ff[g] <= scl_ff[g-1]; sda_ff[g] <= sda_ff[g-1]; end
      end
    end
  end

  assign scl_s   = scl_ff[SYNC-1];
  assign sda_s_o = sda_ff[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin scl_p <= 1'b1; sda_p <= 1'b1; end
    else         begin scl_p <= scl_s; sda_p <= sda_s_o; end
  end

  // SDA edge while SCL stays high
  assign start_o = scl_s && scl_p && sda_p && !sda_s_o;
  assign stop_o  = scl_s && scl_p && !sda_p && sda_s_o;
endmodule

// File: rtl/i2c_ah_engine.sv
module i2c_ah_engine
  import i2c_ah_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          ack_pre_i,
  input  logic          ack_bit_i,
  input  logic          release_i,
  input  logic          tick_i,
  input  logic          sda_s_i,
  input  logic [AW-1:0] addr_i,
  output logic          run_o,
  output logic          done_o,
  output logic          nack_o,
  output logic          arb_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  localparam int unsigned BW = $clog2(AW);

  eng_st_e       st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [AW-1:0] sh_q;
  logic          ackb_q, sda_q, drv;
  logic          load;

  assign load  = go_i && (st_q == E_IDLE || st_q == E_HOLD) && !release_i;
  assign run_o = (st_q != E_IDLE) && (st_q != E_HOLD);

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    done_o = 1'b0;
    nack_o = 1'b0;
    arb_o  = 1'b0;
    if (release_i) begin
      st_d = E_IDLE;
    end else begin
      unique case (st_q)
        E_IDLE:   if (go_i) st_d = E_START;
        E_HOLD:   if (go_i) st_d = ack_pre_i ? E_PRE_LO : E_RS_LO;
        E_PRE_LO: if (tick_i) st_d = E_PRE_HI;
        E_PRE_HI: if (tick_i) st_d = E_RS_LO;
        E_RS_LO:  if (tick_i) st_d = E_RS_HI;
        E_RS_HI:  if (tick_i) st_d = E_START;
        E_START:  if (tick_i) begin st_d = E_BIT_LO; bit_d = BW'(AW-1); end
        E_BIT_LO: if (tick_i) st_d = E_BIT_HI;
        E_BIT_HI: if (tick_i) begin
          if (sh_q[bit_q] && !sda_s_i) begin
            arb_o = 1'b1;
            st_d  = E_IDLE;
          end else if (bit_q == '0) begin
            st_d = E_ACK_LO;
          end else begin
            bit_d = bit_q - 1'b1;
            st_d  = E_BIT_LO;
          end
        end
        E_ACK_LO: if (tick_i) st_d = E_ACK_HI;
        E_ACK_HI: if (tick_i) begin
          done_o = 1'b1;
          nack_o = sda_s_i;
          st_d   = E_HOLD;
        end
        default:  st_d = E_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      E_START:            drv = 1'b1;
      E_BIT_LO, E_BIT_HI: drv = ~sh_q[bit_q];
      E_PRE_LO, E_PRE_HI: drv = ~ackb_q;
      default:            drv = 1'b0;
    endcase
  end

  assign scl_oe_o = (st_q == E_HOLD) || (st_q == E_PRE_LO) || (st_q == E_RS_LO) ||
                    (st_q == E_BIT_LO) || (st_q == E_ACK_LO);
  // one-cycle lag keeps SDA moves inside the SCL low half
  assign sda_oe_o = sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      ackb_q <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      sda_q <= drv;
      if (load) begin
        sh_q   <= addr_i;
        ackb_q <= ack_bit_i;
      end
    end
  end

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_BIT_HI && $past(st_q) == E_BIT_HI) |-> $stable(sda_oe_o)); // R9

  AST_ARB_FREES_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_o && !release_i) |=> (!scl_oe_o && !sda_oe_o)); // R11
endmodule

// File: rtl/i2c_addr_host.sv
module i2c_addr_host
  import i2c_ah_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_we_i,
  input  logic [AW-1:0]    addr_wdata_i,
  input  logic             force_idle_i,
  input  logic             ack_bit_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic [AW-1:0]    addr_o,
  output logic [1:0]       bus_state_o,
  output logic             host_flag_o,
  output logic             bus_err_o,
  output logic             arb_lost_o,
  output logic             rx_nack_o,
  output logic             clk_hold_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  bus_state_e  bs_q, bs_d;
  logic [AW-1:0] addr_q, addr_nx;
  logic host_q, err_q, arb_q, nack_q, hold_q, last_rd_q, pend_q;
  logic wr_unk, wr_idle, wr_busy, wr_own, accept, launch, go;
  logic run, tick, done, nack, arb, sda_s, start_det, stop_det;

  assign wr_unk  = addr_we_i && bs_q == BS_UNKNOWN;
  assign wr_idle = addr_we_i && bs_q == BS_IDLE;
  assign wr_busy = addr_we_i && bs_q == BS_BUSY;
  assign wr_own  = addr_we_i && bs_q == BS_OWNER && host_q && !run;
  assign accept  = wr_unk || wr_idle || wr_busy || wr_own;
  assign launch  = pend_q && bs_q == BS_IDLE;
  assign go      = (wr_idle || wr_own || launch) && !force_idle_i;
  assign addr_nx = accept ? addr_wdata_i : addr_q;

  i2c_ah_mon #(.SYNC(SYNC)) i_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .start_o(start_det), .stop_o(stop_det)
  );

  i2c_ah_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .run_i(run), .div_i(clk_div_i), .tick_o(tick)
  );

  i2c_ah_engine #(.AW(AW)) i_eng (
    .clk_i, .rst_ni, .go_i(go), .ack_pre_i(last_rd_q), .ack_bit_i,
    .release_i(force_idle_i), .tick_i(tick), .sda_s_i(sda_s), .addr_i(addr_nx),
    .run_o(run), .done_o(done), .nack_o(nack), .arb_o(arb),
    .scl_oe_o, .sda_oe_o
  );

  always_comb begin
    bs_d = bs_q;
    if (force_idle_i)                        bs_d = BS_IDLE;
    else if (arb)                            bs_d = BS_BUSY;
    else if (go)                             bs_d = BS_OWNER;
    else if (stop_det)                       bs_d = BS_IDLE;
    else if (start_det && bs_q != BS_OWNER)  bs_d = BS_BUSY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bs_q      <= BS_UNKNOWN;
      addr_q    <= '0;
      host_q    <= 1'b0;
      err_q     <= 1'b0;
      arb_q     <= 1'b0;
      nack_q    <= 1'b0;
      hold_q    <= 1'b0;
      last_rd_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      bs_q   <= bs_d;
      addr_q <= addr_nx;
      if (accept) begin
        host_q <= wr_unk;
        err_q  <= wr_unk;
        arb_q  <= 1'b0;
        nack_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        if (done || arb) host_q <= 1'b1;
        if (arb)         arb_q  <= 1'b1;
        if (done)        nack_q <= nack;
        if (force_idle_i || arb) hold_q <= 1'b0;
        else if (done)           hold_q <= 1'b1;
      end
      if (done) last_rd_q <= addr_q[0];
      if (go)           pend_q <= 1'b0;
      else if (wr_busy) pend_q <= 1'b1;
    end
  end

  assign addr_o      = addr_q;
  assign bus_state_o = bs_q;
  assign host_flag_o = host_q;
  assign bus_err_o   = err_q;
  assign arb_lost_o  = arb_q;
  assign rx_nack_o   = nack_q;
  assign clk_hold_o  = hold_q;

  AST_UNKNOWN_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_we_i && bs_q == BS_UNKNOWN && !force_idle_i) |=>
      (bus_err_o && host_flag_o && !scl_oe_o)); // R3

  AST_WRITE_CLEARS_ARB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!arb_lost_o && !rx_nack_o)); // R8

  AST_REJECT_KEEPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_we_i && bs_q == BS_OWNER && !host_flag_o) |=> $stable(addr_o)); // R7

  AST_HOLD_PULLS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_hold_o |-> scl_oe_o); // R5

  AST_ARB_MARKS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb && !force_idle_i) |=> (bus_state_o == 2'd3 && arb_lost_o)); // R11

  AST_PENDING_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && bs_q == BS_BUSY && !run) |-> !scl_oe_o); // R4
endmodule

// File: tb/test_i2c_addr_host.sv
module test_i2c_addr_host;
  localparam int DIV = 3;
  localparam int T   = DIV + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       we = 1'b0, fidle = 1'b0, ackb = 1'b0;
  logic [7:0] wd = '0;
  logic       slv_drv = 1'b0, om = 1'b0;
  logic [7:0] addr_o;
  logic [1:0] bstate;
  logic host_flag, bus_err, arb_lost, rx_nack, clk_hold, scl_oe, sda_oe;

  wire scl_l = !scl_oe;
  wire sda_l = !(sda_oe | slv_drv | om);

  i2c_addr_host i_i2c_addr_host (
    .clk_i(clk), .rst_ni(rst_n), .addr_we_i(we), .addr_wdata_i(wd),
    .force_idle_i(fidle), .ack_bit_i(ackb), .clk_div_i(8'(DIV)),
    .scl_i(scl_l), .sda_i(sda_l), .addr_o(addr_o), .bus_state_o(bstate),
    .host_flag_o(host_flag), .bus_err_o(bus_err), .arb_lost_o(arb_lost),
    .rx_nack_o(rx_nack), .clk_hold_o(clk_hold), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, t0 = 0, t1 = 0;
  logic [7:0] addr_m = '0;
  bit run_pc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model
  bit ps = 1, pd = 1, pso = 0, ack_en = 1, pre_sda = 1;
  int bitcnt = 9, pre_cnt = 0, last_pre = 0;
  logic [7:0] sh = '0;
  logic [7:0] got_q[$];

  always @(negedge clk) begin
    if (ps && scl_l && pd && !sda_l) begin
      last_pre = pre_cnt; pre_cnt = 0; bitcnt = 0;
    end else if (!ps && scl_l) begin
      if (bitcnt < 8) begin
        sh = {sh[6:0], sda_l}; bitcnt++;
        if (bitcnt == 8) got_q.push_back(sh);
      end else if (bitcnt == 8) bitcnt = 9;
      else begin
        pre_cnt++;
        if (pre_cnt == 1) pre_sda = sda_l;
      end
    end
    if (!scl_l) slv_drv = ack_en && bitcnt == 8;
    if (run_pc) begin
      chk(addr_o === addr_m, "R1 readback", addr_o, addr_m);
      chk(!(ps && scl_l && pso && !sda_oe), "R9 sda release during scl high", 1, 0);
    end
    ps = scl_l; pd = sda_l; pso = sda_oe;
  end

  task automatic wr(input logic [7:0] v, input bit acc);
    @(posedge clk); #1 we = 1'b1; wd = v;
    @(posedge clk); #1 we = 1'b0;
    if (acc) begin addr_m = v; t0 = cyc; end
  endtask

  task automatic wait_flag();
    int n = 0;
    while (!host_flag && n < 3000) begin @(negedge clk); n++; end
    t1 = cyc;
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b;
    bit quiet;
    idle_cyc(3);
    chk(addr_o == 8'h00, "R1 reset addr", addr_o, 0);
    chk(bstate == 2'd0, "R12 reset state unknown", bstate, 0);
    chk({host_flag, bus_err, arb_lost, rx_nack, clk_hold, scl_oe, sda_oe} == 7'b0,
        "R1 reset flags", {host_flag, bus_err, arb_lost, rx_nack, clk_hold}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    run_pc = 1;

    // unknown: error, no traffic
    wr(8'h11, 1);
    quiet = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (scl_oe || sda_oe) quiet = 0; end
    chk(bus_err && host_flag, "R3 unknown write flags", {bus_err, host_flag}, 3);
    chk(quiet, "R3 no line activity", quiet, 1);

    // external START then STOP
    @(posedge clk); #1 om = 1'b1;
    idle_cyc(8);
    chk(bstate == 2'd3, "R12 start -> busy", bstate, 3);
    @(posedge clk); #1 om = 1'b0;
    idle_cyc(8);
    chk(bstate == 2'd1, "R12 stop -> idle", bstate, 1);

    // fresh start, write direction, ACK
    ack_en = 1;
    wr(8'hA4, 1);
    chk(!bus_err, "R8 write clears bus error", bus_err, 0);
    wait_flag();
    chk(t1 - t0 == 19 * T, "R9 fresh transfer duration", t1 - t0, 19 * T);
    idle_cyc(2);
    b = got_q.size() > 0 ? got_q.pop_front() : 8'hxx;
    chk(b == 8'hA4, "R5 address byte on bus", b, 8'hA4);
    chk(clk_hold && !rx_nack && bstate == 2'd2 && !scl_l, "R5 ack hold owner",
        {clk_hold, rx_nack, bstate, scl_l}, 5'b10100);

    // repeated start, read direction, NACK; mid-transfer write rejected
    ack_en = 0;
    wr(8'hA5, 1);
    idle_cyc(30);
    wr(8'h77, 0);
    chk(addr_o == 8'hA5, "R7 write while flag clear ignored", addr_o, 8'hA5);
    wait_flag();
    chk(t1 - t0 == 21 * T, "R9 repeated start duration", t1 - t0, 21 * T);
    idle_cyc(2);
    chk(last_pre == 1, "R2 no ack pulse after write address", last_pre, 1);
    b = got_q.size() > 0 ? got_q.pop_front() : 8'hxx;
    chk(b == 8'hA5, "R7 byte unaffected by rejected write", b, 8'hA5);
    chk(rx_nack && host_flag && !scl_l && bstate == 2'd2, "R10 nack flags and hold",
        {rx_nack, host_flag, scl_l, bstate}, 5'b11010);

    // repeated start after read: ack pre-pulse
    ack_en = 1; ackb = 1'b0;
    wr(8'h3C, 1);
    chk(!rx_nack && !host_flag, "R8 write clears nack and flag", {rx_nack, host_flag}, 0);
    wait_flag();
    chk(t1 - t0 == 23 * T, "R9 repeated start with pre-pulse", t1 - t0, 23 * T);
    idle_cyc(2);
    chk(last_pre == 2 && pre_sda == 1'b0, "R6 ack pre-pulse driven low",
        {last_pre[3:0], pre_sda}, 5'b00100);
    b = got_q.size() > 0 ? got_q.pop_front() : 8'hxx;
    chk(b == 8'h3C, "R6 byte after repeated start", b, 8'h3C);

    // force idle
    @(posedge clk); #1 fidle = 1'b1;
    @(posedge clk); #1 fidle = 1'b0;
    idle_cyc(2);
    chk(bstate == 2'd1 && scl_l && !clk_hold, "R12 force idle releases",
        {bstate, scl_l, clk_hold}, 4'b0110);

    // arbitration loss on first bit
    wr(8'hC2, 1);
    while (!scl_oe) @(negedge clk);
    @(posedge clk); #1 om = 1'b1;
    for (int i = 0; i < 200 && !arb_lost; i++) @(negedge clk);
    idle_cyc(3);
    chk(arb_lost && host_flag && bstate == 2'd3 && !scl_oe && !sda_oe,
        "R11 arbitration lost", {arb_lost, host_flag, bstate, scl_oe, sda_oe}, 6'b111100);

    // pending in busy
    wr(8'h5A, 1);
    chk(!arb_lost && !host_flag, "R8 write clears arb lost", {arb_lost, host_flag}, 0);
    quiet = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (scl_oe || bstate != 2'd3) quiet = 0; end
    chk(quiet, "R4 pending write waits while busy", quiet, 1);
    @(posedge clk); #1 om = 1'b0;
    wait_flag();
    idle_cyc(2);
    b = got_q.size() > 0 ? got_q.pop_front() : 8'hxx;
    chk(b == 8'h5A && bstate == 2'd2 && host_flag, "R4 pending write issued after stop",
        b, 8'h5A);

    run_pc = 0;
    summary();
    $finish;
  end
endmodule